// File: doc/BRIEF.md
# Per-Core Countdown Timer with Prescaler

This block is a countdown timer for a single core. Software programs it through four word-addressed registers: a reload value, the live counter, a control word and a sticky interrupt flag. Once enabled, the counter decrements once every prescaler+1 clock cycles. It runs either in one-shot mode, where it halts at zero, or in auto-reload mode, where it refills from the reload value. Reaching zero sets the flag. The interrupt output is the flag gated by an enable bit in the control word.

The block follows fixed rules for zero values. With a zero prescaler, writing zero to the reload value halts the timer without raising the flag. Writing zero to the counter either halts it without an event or refills it from the reload value. An auto-reload timer with zero reload and zero prescaler fires once and halts. With a nonzero prescaler, the same timer fires every prescaler+1 cycles. Register reads are combinational from the word address. Writes take effect on the clock edge where the write strobe is high.

Top module: `cpu_countdown_timer`

## Requirements
- R1: After reset, all four registers read 0 and the interrupt output is low.
- R2: Word address 0 selects the reload value, 1 the counter, 2 the control word and 3 the status flag. Control bit 0 is enable, bit 1 is auto-reload, bit 2 is interrupt enable and bits 15:8 are the prescaler. Control reads return only these fields, with every other bit 0. Status reads return the flag in bit 0.
- R3: An enabled, running counter decrements once every prescaler+1 cycles. A write to the reload, counter or control register restarts the prescaler phase, so the first decrement after such a write comes prescaler+1 edges later.
- R4: Writing the reload register sets both the reload value and the counter to the written value. The timer then runs if it is enabled and either the prescaler or the written value is nonzero.
- R5: In auto-reload mode, the decrement that takes the counter to 0 sets the flag. The next decrement refills the counter from the reload value, so the period is reload+1 decrements.
- R6: In one-shot mode, the decrement that takes the counter to 0 sets the flag and halts the timer, and the counter stays at 0.
- R7: The interrupt output equals flag AND control bit 2. Writing status with bit 0 set clears the flag. Writing status with bit 0 clear leaves the flag unchanged.
- R8: With the timer enabled and a zero prescaler, writing 0 to the reload register halts it, and the flag is not set.
- R9: With the timer enabled and a zero prescaler, a counter write of 0 in one-shot mode halts the timer with no event. The same write in auto-reload mode with a nonzero reload value loads the counter with the reload value, and counting continues.
- R10: In auto-reload mode with reload 0 and prescaler 0, a nonzero counter counts down, sets the flag once and halts. With reload 0 and a nonzero prescaler, the flag is set again every prescaler+1 cycles.
- R11: Clearing enable halts counting and the counter holds its value. Setting enable resumes counting from the held value. Setting enable in auto-reload mode with a zero prescaler and a zero counter first refills the counter from the reload value.
- R12: While the timer is halted, the counter holds its value and the flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | ADDR_W (2) | Word address of the register |
| bus_wdata_i | input | DATA_W (32) | Write data |
| bus_rdata_o | output | DATA_W (32) | Read data for the addressed register |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: a 32-bit counter, an 8-bit prescaler and a 32-bit data bus. Small reload values keep every countdown to a few cycles, so each zero-value rule and each refill can be observed edge by edge. Prescaler values of 2 and 3 show the phase spacing and the phase restart after a register write. A prescaler of 255 written to the control register covers the top of the field.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // register selectors; software relies on this word order
    typedef enum logic [1:0] {
        SEL_LOAD  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_STAT  = 2'd3
    } reg_sel_e;

    // control word field positions
    localparam int CTL_EN_BIT    = 0;
    localparam int CTL_PER_BIT   = 1;
    localparam int CTL_IE_BIT    = 2;
    localparam int CTL_PRESC_LSB = 8;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic               restart_i,
    input  logic [PRESC_W-1:0] presc_i,
    output logic               tick_o
);

    typedef struct packed {
        logic [PRESC_W-1:0] phase;
    } ps_t;

    ps_t ps_d, ps_q;

    always_comb begin
        ps_d = ps_q;
        if (!run_i || restart_i) begin
            ps_d.phase = '0;
        end else if (ps_q.phase == presc_i) begin
            ps_d.phase = '0;
        end else begin
            ps_d.phase = ps_q.phase + PRESC_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q <= '0;
        end else begin
            ps_q <= ps_d;
        end
    end

    assign tick_o = run_i && !restart_i && (ps_q.phase == presc_i);

    // R3: with a nonzero prescaler, two ticks are never back to back
    p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && presc_i != '0 && !restart_i) |=> !tick_o);

endmodule

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode
    import tmr_pkg::*;
#(
    parameter int ADDR_W  = 2,
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 32,
    parameter int PRESC_W = 8
) (
    input  logic               wr_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic [CNT_W-1:0]   load_i,
    input  logic [CNT_W-1:0]   count_i,
    input  logic               en_i,
    input  logic               per_i,
    input  logic               ie_i,
    input  logic [PRESC_W-1:0] presc_i,
    input  logic               status_i,
    output logic               wr_load_o,
    output logic               wr_count_o,
    output logic               wr_ctrl_o,
    output logic               wr_stat_o,
    output logic [CNT_W-1:0]   val_o,
    output logic               n_en_o,
    output logic               n_per_o,
    output logic               n_ie_o,
    output logic [PRESC_W-1:0] n_presc_o,
    output logic               clr_o,
    output logic [DATA_W-1:0]  rdata_o
);

    reg_sel_e sel;
    logic     unused_wbits;

    assign sel = reg_sel_e'(addr_i[1:0]);

    assign wr_load_o  = wr_i && (sel == SEL_LOAD);
    assign wr_count_o = wr_i && (sel == SEL_COUNT);
    assign wr_ctrl_o  = wr_i && (sel == SEL_CTRL);
    assign wr_stat_o  = wr_i && (sel == SEL_STAT);

    assign val_o     = wdata_i[CNT_W-1:0];
    assign n_en_o    = wdata_i[CTL_EN_BIT];
    assign n_per_o   = wdata_i[CTL_PER_BIT];
    assign n_ie_o    = wdata_i[CTL_IE_BIT];
    assign n_presc_o = wdata_i[CTL_PRESC_LSB +: PRESC_W];
    assign clr_o     = wdata_i[0];

    // reserved write bits are discarded
    assign unused_wbits = ^wdata_i;

    always_comb begin
        rdata_o = '0;
        unique case (sel)
            SEL_LOAD:  rdata_o[CNT_W-1:0] = load_i;
            SEL_COUNT: rdata_o[CNT_W-1:0] = count_i;
            SEL_CTRL: begin
                rdata_o[CTL_EN_BIT]                = en_i;
                rdata_o[CTL_PER_BIT]               = per_i;
                rdata_o[CTL_IE_BIT]                = ie_i;
                rdata_o[CTL_PRESC_LSB +: PRESC_W]  = presc_i;
            end
            SEL_STAT:  rdata_o[0] = status_i;
            default:   rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
    parameter int CNT_W   = 32,
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               wr_load_i,
    input  logic               wr_count_i,
    input  logic               wr_ctrl_i,
    input  logic               wr_stat_i,
    input  logic [CNT_W-1:0]   val_i,
    input  logic               n_en_i,
    input  logic               n_per_i,
    input  logic               n_ie_i,
    input  logic [PRESC_W-1:0] n_presc_i,
    input  logic               clr_i,
    output logic [CNT_W-1:0]   load_o,
    output logic [CNT_W-1:0]   count_o,
    output logic               en_o,
    output logic               per_o,
    output logic               ie_o,
    output logic [PRESC_W-1:0] presc_o,
    output logic               status_o,
    output logic               running_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0]   load;
        logic [CNT_W-1:0]   count;
        logic               en;
        logic               per;
        logic               ie;
        logic [PRESC_W-1:0] presc;
        logic               status;
        logic               running;
    } core_t;

    core_t st_d, st_q;
    logic  fire;
    logic  presc_nz;
    logic  any_cfg_wr;
    logic [CNT_W-1:0] cnt_val;

    assign presc_nz   = (st_q.presc != '0);
    assign any_cfg_wr = wr_load_i || wr_count_i || wr_ctrl_i;

    always_comb begin
        st_d    = st_q;
        fire    = 1'b0;
        cnt_val = val_i;
        if (wr_load_i) begin
            st_d.load    = val_i;
            st_d.count   = val_i;
            st_d.running = st_q.en && (presc_nz || val_i != '0);
        end else if (wr_count_i) begin
            if (st_q.en && st_q.per && !presc_nz && val_i == '0) begin
                cnt_val = st_q.load;
            end
            st_d.count   = cnt_val;
            st_d.running = st_q.en && (presc_nz || cnt_val != '0);
        end else if (wr_ctrl_i) begin
            st_d.en    = n_en_i;
            st_d.per   = n_per_i;
            st_d.ie    = n_ie_i;
            st_d.presc = n_presc_i;
            cnt_val    = st_q.count;
            if (n_en_i && n_per_i && st_q.count == '0 && n_presc_i == '0) begin
                cnt_val = st_q.load;
            end
            st_d.count   = cnt_val;
            st_d.running = n_en_i && (n_presc_i != '0 || cnt_val != '0);
        end else if (tick_i) begin
            if (st_q.count != '0) begin
                st_d.count = st_q.count - CNT_ONE;
                if (st_q.count == CNT_ONE) begin
                    fire = 1'b1;
                    if (!st_q.per || (st_q.load == '0 && !presc_nz)) begin
                        st_d.running = 1'b0;
                    end
                end
            end else if (st_q.per) begin
                st_d.count = st_q.load;
                if (st_q.load == '0) begin
                    fire = 1'b1;
                end
            end else begin
                fire         = 1'b1;
                st_d.running = 1'b0;
            end
        end
        if (wr_stat_i && clr_i) begin
            st_d.status = 1'b0;
        end
        if (fire) begin
            st_d.status = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_o    = st_q.load;
    assign count_o   = st_q.count;
    assign en_o      = st_q.en;
    assign per_o     = st_q.per;
    assign ie_o      = st_q.ie;
    assign presc_o   = st_q.presc;
    assign status_o  = st_q.status;
    assign running_o = st_q.running;

    // R12: a halted timer with no configuration write keeps its count and raises no flag
    p_halt_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.running && !any_cfg_wr) |=> ($stable(st_q.count) && !$rose(st_q.status)));

    // R6: one-shot expiry halts at zero with the flag set
    p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && st_q.running && !st_q.per && st_q.count == CNT_ONE && !any_cfg_wr)
        |=> (!st_q.running && st_q.count == '0 && st_q.status));

    // R5: auto-reload refill from the reload value on the tick at zero
    p_refill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && st_q.running && st_q.per && st_q.count == '0 && !any_cfg_wr)
        |=> (st_q.count == $past(st_q.load)));

    // R7: a write-one to status clears the flag when no expiry coincides
    p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat_i && clr_i && !tick_i) |=> !st_q.status);

    // R8: zero reload with zero prescaler halts without an event
    p_zero_load_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_load_i && st_q.en && !presc_nz && val_i == '0)
        |=> (!st_q.running && $stable(st_q.status)));

endmodule

// File: rtl/cpu_countdown_timer.sv
module cpu_countdown_timer #(
    parameter int ADDR_W  = 2,
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 32,
    parameter int PRESC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);

    logic               wr_load, wr_count, wr_ctrl, wr_stat;
    logic [CNT_W-1:0]   wval;
    logic               n_en, n_per, n_ie, clr;
    logic [PRESC_W-1:0] n_presc;
    logic [CNT_W-1:0]   load_v, count_v;
    logic               en_v, per_v, ie_v, status_v, running_v;
    logic [PRESC_W-1:0] presc_v;
    logic               tick;

    tmr_bus_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .PRESC_W(PRESC_W)
    ) u_decode (
        .wr_i      (bus_wr_i),
        .addr_i    (bus_addr_i),
        .wdata_i   (bus_wdata_i),
        .load_i    (load_v),
        .count_i   (count_v),
        .en_i      (en_v),
        .per_i     (per_v),
        .ie_i      (ie_v),
        .presc_i   (presc_v),
        .status_i  (status_v),
        .wr_load_o (wr_load),
        .wr_count_o(wr_count),
        .wr_ctrl_o (wr_ctrl),
        .wr_stat_o (wr_stat),
        .val_o     (wval),
        .n_en_o    (n_en),
        .n_per_o   (n_per),
        .n_ie_o    (n_ie),
        .n_presc_o (n_presc),
        .clr_o     (clr),
        .rdata_o   (bus_rdata_o)
    );

    tmr_prescaler #(
        .PRESC_W(PRESC_W)
    ) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (running_v),
        .restart_i(wr_load || wr_count || wr_ctrl),
        .presc_i  (presc_v),
        .tick_o   (tick)
    );

    tmr_count_core #(
        .CNT_W  (CNT_W),
        .PRESC_W(PRESC_W)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .wr_load_i (wr_load),
        .wr_count_i(wr_count),
        .wr_ctrl_i (wr_ctrl),
        .wr_stat_i (wr_stat),
        .val_i     (wval),
        .n_en_i    (n_en),
        .n_per_i   (n_per),
        .n_ie_i    (n_ie),
        .n_presc_i (n_presc),
        .clr_i     (clr),
        .load_o    (load_v),
        .count_o   (count_v),
        .en_o      (en_v),
        .per_o     (per_v),
        .ie_o      (ie_v),
        .presc_o   (presc_v),
        .status_o  (status_v),
        .running_o (running_v)
    );

    assign irq_o = status_v && ie_v;

    // R7: the interrupt line never rises while its enable is clear
    p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie_v && !wr_ctrl) |=> !irq_o);

endmodule

// File: tb/cpu_countdown_timer_tb.sv
module cpu_countdown_timer_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] A_LOAD = 2'd0;
    localparam logic [1:0] A_CNT  = 2'd1;
    localparam logic [1:0] A_CTL  = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    cpu_countdown_timer #(
        .ADDR_W (2),
        .DATA_W (32),
        .CNT_W  (32),
        .PRESC_W(8)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr_i   (wr),
        .bus_addr_i (addr),
        .bus_wdata_i(wdata),
        .bus_rdata_o(rdata),
        .irq_o      (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        summary();
        $finish;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr = 1'b0;
        wait_edges(2);
        rst_n = 1'b1;
        wait_edges(1);
    endtask

    // called at a negedge; commits on the following posedge
    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        wr = 1'b1;
        addr = a;
        wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic chk_reg(input string req, input logic [1:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_read(a, v);
        chk(req, $sformatf("reg%0d", a), v, exp);
    endtask

    task automatic t_reset();
        do_reset();
        chk_reg("R1", A_LOAD, 0);
        chk_reg("R1", A_CNT, 0);
        chk_reg("R1", A_CTL, 0);
        chk_reg("R1", A_STAT, 0);
        chk("R1", "irq", {31'd0, irq}, 0);
    endtask

    task automatic t_readback();
        do_reset();
        bus_write(A_LOAD, 32'h1234);
        chk_reg("R4", A_LOAD, 32'h1234);
        chk_reg("R4", A_CNT, 32'h1234);
        bus_write(A_CTL, 32'hFFFF_FF06);
        chk_reg("R2", A_CTL, 32'h0000_FF06);
        wait_edges(20);
        chk_reg("R12", A_CNT, 32'h1234);
        chk_reg("R12", A_STAT, 0);
    endtask

    task automatic t_oneshot();
        do_reset();
        bus_write(A_CTL, 32'h5);
        bus_write(A_LOAD, 3);
        wait_edges(2);
        chk_reg("R6", A_CNT, 1);
        chk("R7", "irq before expiry", {31'd0, irq}, 0);
        wait_edges(1);
        chk_reg("R6", A_CNT, 0);
        chk_reg("R6", A_STAT, 1);
        chk("R7", "irq at expiry", {31'd0, irq}, 1);
        wait_edges(5);
        chk_reg("R6", A_CNT, 0);
        bus_write(A_STAT, 0);
        chk_reg("R7", A_STAT, 1);
        bus_write(A_STAT, 1);
        chk_reg("R7", A_STAT, 0);
        chk("R7", "irq after clear", {31'd0, irq}, 0);
    endtask

    task automatic t_periodic();
        do_reset();
        bus_write(A_CTL, 32'h3);
        bus_write(A_LOAD, 2);
        wait_edges(2);
        chk_reg("R5", A_CNT, 0);
        chk_reg("R5", A_STAT, 1);
        chk("R7", "irq masked", {31'd0, irq}, 0);
        wait_edges(1);
        chk_reg("R5", A_CNT, 2);
        wait_edges(1);
        chk_reg("R5", A_CNT, 1);
    endtask

    task automatic t_prescaler();
        do_reset();
        bus_write(A_CTL, 32'h301);
        bus_write(A_LOAD, 10);
        wait_edges(3);
        chk_reg("R3", A_CNT, 10);
        wait_edges(1);
        chk_reg("R3", A_CNT, 9);
        wait_edges(4);
        chk_reg("R3", A_CNT, 8);
        wait_edges(2);
        bus_write(A_CNT, 5);
        wait_edges(3);
        chk_reg("R3", A_CNT, 5);
        wait_edges(1);
        chk_reg("R3", A_CNT, 4);
    endtask

    task automatic t_zero_load();
        do_reset();
        bus_write(A_CTL, 32'h5);
        bus_write(A_LOAD, 5);
        wait_edges(2);
        chk_reg("R4", A_CNT, 3);
        bus_write(A_LOAD, 0);
        chk_reg("R8", A_CNT, 0);
        wait_edges(6);
        chk_reg("R8", A_STAT, 0);
        chk("R8", "irq", {31'd0, irq}, 0);
    endtask

    task automatic t_zero_count();
        do_reset();
        bus_write(A_CTL, 32'h5);
        bus_write(A_LOAD, 5);
        wait_edges(1);
        bus_write(A_CNT, 0);
        wait_edges(4);
        chk_reg("R9", A_CNT, 0);
        chk_reg("R9", A_STAT, 0);
        do_reset();
        bus_write(A_CTL, 32'h7);
        bus_write(A_LOAD, 4);
        wait_edges(1);
        bus_write(A_CNT, 0);
        chk_reg("R9", A_CNT, 4);
        wait_edges(1);
        chk_reg("R9", A_CNT, 3);
    endtask

    task automatic t_zero_reload_periodic();
        do_reset();
        bus_write(A_CTL, 32'h7);
        bus_write(A_LOAD, 0);
        bus_write(A_CNT, 2);
        wait_edges(2);
        chk_reg("R10", A_STAT, 1);
        chk_reg("R10", A_CNT, 0);
        bus_write(A_STAT, 1);
        wait_edges(5);
        chk_reg("R10", A_STAT, 0);
        do_reset();
        bus_write(A_CTL, 32'h207);
        bus_write(A_LOAD, 0);
        wait_edges(2);
        chk_reg("R10", A_STAT, 0);
        wait_edges(1);
        chk_reg("R10", A_STAT, 1);
        bus_write(A_STAT, 1);
        chk_reg("R10", A_STAT, 0);
        wait_edges(1);
        chk_reg("R10", A_STAT, 0);
        wait_edges(1);
        chk_reg("R10", A_STAT, 1);
        chk("R7", "irq periodic", {31'd0, irq}, 1);
    endtask

    task automatic t_enable();
        do_reset();
        bus_write(A_CTL, 32'h5);
        bus_write(A_LOAD, 6);
        wait_edges(2);
        bus_write(A_CTL, 32'h4);
        wait_edges(5);
        chk_reg("R11", A_CNT, 4);
        bus_write(A_CTL, 32'h5);
        wait_edges(1);
        chk_reg("R11", A_CNT, 3);
        do_reset();
        bus_write(A_CTL, 32'h1);
        bus_write(A_LOAD, 2);
        wait_edges(2);
        chk_reg("R6", A_CNT, 0);
        bus_write(A_CTL, 32'h3);
        chk_reg("R11", A_CNT, 2);
        wait_edges(1);
        chk_reg("R11", A_CNT, 1);
    endtask

    initial begin
        t_reset();
        t_readback();
        t_oneshot();
        t_periodic();
        t_prescaler();
        t_zero_load();
        t_zero_count();
        t_zero_reload_periodic();
        t_enable();
        summary();
        $finish;
    end

endmodule